// File: doc/BRIEF.md
# Miss-Dependent Slice Buffer

This block sits between decode and execute. While a long-latency load miss is outstanding, decoding keeps going. Each decoded instruction is sorted by whether it needs the missing value. It needs the value if it reads the miss destination, or if it reads a register written by an instruction that already needs the value. Such an instruction goes into an in-order slice FIFO, so it holds no scheduler resources while it waits. Every other instruction goes straight to the execute port.

A table holds one pending bit per architectural register. The miss destination sets its bit. A stored instruction sets the bit of its own destination. An instruction that goes to execute and writes a pending register clears that register's bit.

When the miss completes, the block sends only the stored instructions to execute, one per cycle and in program order, each marked as a replay. Decode input is held off until the FIFO has drained. Instructions that already went to execute are not sent again.

Top module: `miss_slice_buffer`

## Requirements
- R1: While reset is asserted and right after it, `in_ready_o` is 1, `ex_valid_o` is 0 and the block is in pass-through mode.
- R2: In pass-through mode, an accepted instruction appears on the execute port in the same cycle with `ex_replay_o` = 0 and unchanged fields.
- R3: A `miss_start_i` pulse in pass-through mode marks `miss_dst_i` as pending. A later instruction that reads that register on either source is stored and not issued.
- R4: An instruction that reads the destination of a stored instruction is stored as well. Only a stored instruction with `in_wr_i` = 1 marks its destination as pending.
- R5: While a miss is outstanding, an instruction whose two sources are not pending goes to execute in the cycle it is accepted, with `ex_replay_o` = 0.
- R6: An instruction that goes to execute with `in_wr_i` = 1 clears the pending mark of its destination. A later reader of that register then goes to execute.
- R7: The slice FIFO holds 16 instructions. When it is full, `in_ready_o` is 0.
- R8: When `miss_done_i` arrives with stored instructions, they are issued in store order, one per cycle, starting the cycle after `miss_done_i`, each with `ex_replay_o` = 1.
- R9: `in_ready_o` is 0 in the cycle `miss_done_i` is seen and throughout replay. It returns to 1 in the cycle after the last replayed instruction.
- R10: A `miss_done_i` pulse that arrives while the FIFO is empty returns the block to pass-through mode in the next cycle, and no instruction is replayed.
- R11: `in_ready_o` is 0 in the cycle a miss starts in pass-through mode. A `miss_start_i` pulse while a miss is already outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Decoded instruction valid |
| in_ready_o | output | 1 | Block can accept the decoded instruction |
| in_src_a_i | input | 5 | First source register |
| in_src_b_i | input | 5 | Second source register |
| in_dst_i | input | 5 | Destination register |
| in_wr_i | input | 1 | Instruction writes its destination |
| in_tag_i | input | 8 | Instruction identifier |
| miss_start_i | input | 1 | A load miss has started |
| miss_dst_i | input | 5 | Destination register of the missing load |
| miss_done_i | input | 1 | The outstanding miss has returned |
| ex_valid_o | output | 1 | Instruction issued to execute |
| ex_replay_o | output | 1 | The issued instruction comes from the slice FIFO |
| ex_src_a_o | output | 5 | First source of the issued instruction |
| ex_src_b_o | output | 5 | Second source of the issued instruction |
| ex_dst_o | output | 5 | Destination of the issued instruction |
| ex_wr_o | output | 1 | Issued instruction writes its destination |
| ex_tag_o | output | 8 | Identifier of the issued instruction |

## Verification
The hardest state to reach is a long, mixed dependence chain while one miss is outstanding. The chain must reach stored instructions through each source operand and through a transitive link. It must also contain an independent write that removes a register from the slice, and a second miss request that has to be ignored.

The stimulus builds this chain one instruction at a time. A reference model in the bench tracks the pending registers and predicts the issue order, immediate issues and replays alike. A second run fills the FIFO with sixteen chained instructions, so the full-buffer stall and a full-length ordered replay are both exercised.

// File: rtl/msb_pkg.sv
package msb_pkg;
  parameter int unsigned REG_W    = 5;
  parameter int unsigned NUM_REGS = 1 << REG_W;
  parameter int unsigned TAG_W    = 8;

  typedef enum logic [1:0] {
    MODE_PASS   = 2'd0,
    MODE_SHADOW = 2'd1,
    MODE_REPLAY = 2'd2
  } mode_e;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic             wr;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src_b;
    logic [REG_W-1:0] src_a;
  } slot_t;
endpackage

// File: rtl/msb_wait_table.sv
module msb_wait_table #(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_all_i,
  input  logic                set_i,
  input  logic [IDX_W-1:0]    set_idx_i,
  input  logic                clr_i,
  input  logic [IDX_W-1:0]    clr_idx_i,
  output logic [NUM_REGS-1:0] bits_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        bits_o[g] <= 1'b0;
      else if (clr_all_i)                                 bits_o[g] <= 1'b0;
      else if (set_i && set_idx_i == IDX_W'(g))           bits_o[g] <= 1'b1;
      else if (clr_i && clr_idx_i == IDX_W'(g))           bits_o[g] <= 1'b0;
    end
  end

  // R3
  set_marks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_all_i) |=> bits_o[$past(set_idx_i)]);
  // R6
  clr_unmarks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i && !clr_all_i) |=> !bits_o[$past(clr_idx_i)]);
endmodule

// File: rtl/msb_fifo.sv
module msb_fifo #(
  parameter int unsigned WIDTH = 20,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign data_o  = mem_q[rd_ptr_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign count_o = cnt_q;

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_q < CNT_W'(DEPTH)));
  // R8
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));
endmodule

// File: rtl/miss_slice_buffer.sv
module miss_slice_buffer
  import msb_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [REG_W-1:0] in_src_a_i,
  input  logic [REG_W-1:0] in_src_b_i,
  input  logic [REG_W-1:0] in_dst_i,
  input  logic             in_wr_i,
  input  logic [TAG_W-1:0] in_tag_i,
  input  logic             miss_start_i,
  input  logic [REG_W-1:0] miss_dst_i,
  input  logic             miss_done_i,
  output logic             ex_valid_o,
  output logic             ex_replay_o,
  output logic [REG_W-1:0] ex_src_a_o,
  output logic [REG_W-1:0] ex_src_b_o,
  output logic [REG_W-1:0] ex_dst_o,
  output logic             ex_wr_o,
  output logic [TAG_W-1:0] ex_tag_o
);
  localparam int unsigned SLOT_W = $bits(slot_t);
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1);

  mode_e mode_q, mode_d;
  logic [NUM_REGS-1:0] pend;
  logic accept, dep, push, pop, direct;
  logic fifo_empty, fifo_full;
  logic [CNT_W-1:0] fifo_cnt;
  slot_t in_slot, head;
  logic [SLOT_W-1:0] head_raw;
  logic set_en, clr_en, clr_all;
  logic [REG_W-1:0] set_idx;

  assign in_slot = '{tag: in_tag_i, wr: in_wr_i, dst: in_dst_i,
                     src_b: in_src_b_i, src_a: in_src_a_i};
  assign head = slot_t'(head_raw);

  assign in_ready_o = (mode_q == MODE_PASS   && !miss_start_i) ||
                      (mode_q == MODE_SHADOW && !fifo_full && !miss_done_i);
  assign accept = in_valid_i && in_ready_o;
  assign dep    = pend[in_src_a_i] || pend[in_src_b_i];
  assign push   = accept && mode_q == MODE_SHADOW && dep;
  assign direct = accept && !push;
  assign pop    = mode_q == MODE_REPLAY && !fifo_empty;

  // pending-mark updates: miss start in pass mode, or a stored writer
  assign set_en  = (mode_q == MODE_PASS && miss_start_i) || (push && in_wr_i);
  assign set_idx = (mode_q == MODE_PASS) ? miss_dst_i : in_dst_i;
  assign clr_en  = direct && mode_q == MODE_SHADOW && in_wr_i;
  assign clr_all = mode_q == MODE_SHADOW && miss_done_i;

  msb_wait_table #(.NUM_REGS(NUM_REGS)) u_wait (
    .clk_i, .rst_ni,
    .clr_all_i (clr_all),
    .set_i     (set_en),
    .set_idx_i (set_idx),
    .clr_i     (clr_en),
    .clr_idx_i (in_dst_i),
    .bits_o    (pend)
  );

  msb_fifo #(.WIDTH(SLOT_W), .DEPTH(DEPTH)) u_slice (
    .clk_i, .rst_ni,
    .push_i  (push),
    .data_i  (in_slot),
    .pop_i   (pop),
    .data_o  (head_raw),
    .empty_o (fifo_empty),
    .full_o  (fifo_full),
    .count_o (fifo_cnt)
  );

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_PASS:   if (miss_start_i) mode_d = MODE_SHADOW;
      MODE_SHADOW: if (miss_done_i)  mode_d = fifo_empty ? MODE_PASS : MODE_REPLAY;
      MODE_REPLAY: if (fifo_cnt <= CNT_W'(1)) mode_d = MODE_PASS;
      default:     mode_d = MODE_PASS;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_PASS;
    else         mode_q <= mode_d;
  end

  always_comb begin
    if (pop) begin
      ex_src_a_o = head.src_a;
      ex_src_b_o = head.src_b;
      ex_dst_o   = head.dst;
      ex_wr_o    = head.wr;
      ex_tag_o   = head.tag;
    end else begin
      ex_src_a_o = in_src_a_i;
      ex_src_b_o = in_src_b_i;
      ex_dst_o   = in_dst_i;
      ex_wr_o    = in_wr_i;
      ex_tag_o   = in_tag_i;
    end
  end
  assign ex_valid_o  = direct || pop;
  assign ex_replay_o = pop;

  // R9
  no_accept_in_replay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_replay_o |-> !(in_valid_i && in_ready_o));
  // R10
  empty_done_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SHADOW && miss_done_i && fifo_empty) |=> (mode_q == MODE_PASS && !ex_replay_o));
  // R2
  pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_PASS && in_valid_i && !miss_start_i) |->
      (ex_valid_o && !ex_replay_o && ex_tag_o == in_tag_i));
  // R8
  replay_until_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && fifo_cnt > CNT_W'(1)) |=> ex_replay_o);
endmodule

// File: tb/miss_slice_buffer_test.sv
module miss_slice_buffer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid_i = 1'b0, in_wr_i = 1'b0;
  logic [4:0] in_src_a_i = '0, in_src_b_i = '0, in_dst_i = '0, miss_dst_i = '0;
  logic [7:0] in_tag_i = '0;
  logic miss_start_i = 1'b0, miss_done_i = 1'b0;
  logic in_ready_o, ex_valid_o, ex_replay_o, ex_wr_o;
  logic [4:0] ex_src_a_o, ex_src_b_o, ex_dst_o;
  logic [7:0] ex_tag_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  miss_slice_buffer uut (
    .clk_i(clk), .rst_ni,
    .in_valid_i, .in_ready_o, .in_src_a_i, .in_src_b_i, .in_dst_i, .in_wr_i, .in_tag_i,
    .miss_start_i, .miss_dst_i, .miss_done_i,
    .ex_valid_o, .ex_replay_o, .ex_src_a_o, .ex_src_b_o, .ex_dst_o, .ex_wr_o, .ex_tag_o
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // reference model
  bit m_shadow = 0;
  bit m_pend [32];
  int exp_tag [$];
  bit exp_rep [$];
  string exp_req [$];
  int stored [$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni && ex_valid_o) begin
      if (exp_tag.size() == 0) begin
        chk(0, "R5 unexpected issue", ex_tag_o, -1);
      end else begin
        automatic int t = exp_tag.pop_front();
        automatic bit r = exp_rep.pop_front();
        automatic string q = exp_req.pop_front();
        chk(ex_tag_o == t[7:0], q, ex_tag_o, t);
        chk(ex_replay_o == r, {q, " replay flag"}, ex_replay_o, r);
      end
    end
  end

  task automatic send(input int a, input int b, input int d, input bit wr,
                      input int tag, input string req);
    in_src_a_i = a[4:0]; in_src_b_i = b[4:0]; in_dst_i = d[4:0];
    in_wr_i = wr; in_tag_i = tag[7:0]; in_valid_i = 1'b1;
    if (!m_shadow) begin
      exp_tag.push_back(tag); exp_rep.push_back(0); exp_req.push_back(req);
    end else if (m_pend[a] || m_pend[b]) begin
      stored.push_back(tag);
      if (wr) m_pend[d] = 1;
    end else begin
      exp_tag.push_back(tag); exp_rep.push_back(0); exp_req.push_back(req);
      if (wr) m_pend[d] = 0;
    end
    #1;
    chk(in_ready_o == 1'b1, {req, " ready"}, in_ready_o, 1);
    @(posedge clk); #1;
    in_valid_i = 1'b0;
  endtask

  task automatic miss(input int d);
    miss_dst_i = d[4:0]; miss_start_i = 1'b1;
    #1;
    if (!m_shadow) chk(in_ready_o == 1'b0, "R11 ready in miss-start cycle", in_ready_o, 0);
    if (!m_shadow) begin m_shadow = 1; m_pend[d] = 1; end
    @(posedge clk); #1;
    miss_start_i = 1'b0;
  endtask

  task automatic done();
    int n;
    miss_done_i = 1'b1;
    #1;
    chk(in_ready_o == 1'b0, "R9 ready in done cycle", in_ready_o, 0);
    @(posedge clk); #1;
    miss_done_i = 1'b0;
    n = stored.size();
    foreach (stored[i]) begin
      exp_tag.push_back(stored[i]); exp_rep.push_back(1); exp_req.push_back("R8 replay order");
    end
    stored.delete();
    foreach (m_pend[i]) m_pend[i] = 0;
    m_shadow = 0;
    if (n == 0) begin
      chk(in_ready_o == 1'b1, "R10 pass after empty done", in_ready_o, 1);
    end else begin
      chk(in_ready_o == 1'b0, "R9 ready during replay", in_ready_o, 0);
      repeat (n) begin @(posedge clk); #1; end
      chk(in_ready_o == 1'b1, "R9 ready after drain", in_ready_o, 1);
    end
    chk(exp_tag.size() == 0, "R8 all replays issued", exp_tag.size(), 0);
  endtask

  initial begin
    foreach (m_pend[i]) m_pend[i] = 0;
    repeat (2) @(posedge clk);
    #1;
    chk(in_ready_o == 1'b1, "R1 reset ready", in_ready_o, 1);
    chk(ex_valid_o == 1'b0, "R1 reset ex_valid", ex_valid_o, 0);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    @(posedge clk); #1;
    chk(in_ready_o == 1'b1, "R1 ready after reset", in_ready_o, 1);

    // pass-through
    send(1, 2, 3, 1, 1, "R2 pass");
    send(3, 3, 4, 1, 2, "R2 pass");
    send(5, 6, 7, 0, 3, "R2 pass");

    // mixed chain under one miss
    miss(5);
    send(5, 0, 6, 1, 10, "R3 reader of miss dst");
    send(1, 2, 7, 1, 11, "R5 independent");
    send(0, 6, 8, 1, 12, "R4 transitive via src_b");
    send(3, 3, 5, 1, 13, "R6 independent writer");
    send(5, 1, 9, 1, 14, "R6 reader after clear");
    send(8, 2, 11, 0, 15, "R4 transitive no write");
    send(11, 2, 12, 1, 17, "R4 non-writer leaves dst clear");
    miss(9);
    send(9, 0, 10, 1, 16, "R11 second miss ignored");
    done();

    // empty done
    miss(4);
    done();
    send(4, 4, 4, 1, 20, "R10 pass after empty done");

    // fill the slice FIFO
    miss(1);
    for (int i = 0; i < 16; i++) send(1, 0, 1, 1, 30 + i, "R7 fill");
    in_src_a_i = 5'd1; in_src_b_i = 5'd1; in_dst_i = 5'd2; in_wr_i = 1'b1;
    in_tag_i = 8'd99; in_valid_i = 1'b1;
    #1;
    chk(in_ready_o == 1'b0, "R7 full stall", in_ready_o, 0);
    @(posedge clk); #1;
    in_valid_i = 1'b0;
    done();
    send(2, 3, 4, 1, 50, "R2 pass after replay");

    @(posedge clk); #1;
    chk(exp_tag.size() == 0, "R5 scoreboard empty", exp_tag.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule